// File: doc/BRIEF.md
# Multiplexed Display RAM Loader

This block takes display data bytes that arrive one at a time from a serial-bus slave front end and writes them into a segment display RAM. The RAM has 40 segment columns and 4 backplane rows, with one bit for each segment and backplane pair. A column pointer chooses where each write lands. The multiplex drive mode sets how many bits of a byte go into one column: one bit in static mode, two in 1:2, three in 1:3 and four in 1:4. After each group is written, the pointer moves on by one column, so a run of bytes fills neighbouring columns.

The block has one state machine with two states. **ST_IDLE** waits for a byte or a pointer load. When a byte arrives, the transition *accept* moves to **ST_UNPACK**. In ST_UNPACK the block writes one column per cycle and raises `busy`. The front end uses `busy` as its stall: it holds the bus clock low and offers no new byte until `busy` drops. The transition *drain* returns to ST_IDLE after the last complete group of the byte has been written. In 1:3 mode a byte does not divide into whole triplets. The bits left over are kept and become the first bits of the next byte's first triplet.

When the pointer passes the last column, it wraps to 0 and a subaddress counter goes up by one. Writes are enabled only while that counter equals the device's hardware subaddress. This lets several devices that share one byte stream each take their own share.

Top module: `seg_ram_loader`

## Requirements
- R1: After reset, `busy` and `wr_en` are low, the pointer is at column 0 and the subaddress counter is 0.
- R2: In static mode (`mux_mode`=0) a byte produces 8 writes. Each write has `wr_mask`=4'b0001. Byte bit 7 is written first, into `wr_data[0]`.
- R3: In 1:2 mode (`mux_mode`=1) a byte produces 4 writes with `wr_mask`=4'b0011. Of each pair, the earlier (more significant) bit goes to row 0 and the later bit to row 1.
- R4: In 1:4 mode (`mux_mode`=3) a byte produces 2 writes with `wr_mask`=4'b1111. Bit 7 goes to row 0 and bit 4 to row 3 in the first column. Bits 3 to 0 go to rows 0 to 3 of the next column.
- R5: In 1:3 mode (`mux_mode`=2) the leftover bits of a byte are carried ahead of the next byte's bits. Bytes therefore produce 2, 3 and 3 writes in turn, each with `wr_mask`=4'b0111.
- R6: The first write comes in the cycle after a byte is accepted. `busy` is high for exactly as many cycles as there are writes. A byte offered while `busy` is high is ignored.
- R7: The pointer goes up by one after each write. From column 39 it wraps to column 0.
- R8: A wrap increments the 3-bit subaddress counter. `wr_en` is high only in busy cycles where the counter equals `hw_sub`. The pointer still advances when writes are disabled.
- R9: A pointer load taken while idle sets the column to `ptr_val`. A value of 40 or more becomes 39. A load requested while `busy` is high is ignored.
- R10: A pointer load or a change of `mux_mode` at the moment a byte is accepted discards any carried 1:3 bits. When a load and a byte arrive in the same idle cycle, the byte starts at the loaded column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_vld | input | 1 | Display byte strobe, taken only while idle |
| byte_data | input | 8 | Display byte |
| ptr_ld | input | 1 | Pointer load request, taken only while idle |
| ptr_val | input | 6 | Pointer load value |
| mux_mode | input | 2 | 0 static, 1 for 1:2, 2 for 1:3, 3 for 1:4 |
| hw_sub | input | 3 | Hardware subaddress of this device |
| busy | output | 1 | Unpacking in progress; upstream must stall |
| wr_en | output | 1 | RAM write enable |
| wr_col | output | 6 | RAM column being written |
| wr_mask | output | 4 | Rows written in this cycle |
| wr_data | output | 4 | Row bits, row 0 in bit 0 |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a pointer load arriving in the same idle cycle as a byte. The bench provokes this directly, and it is judged by the column of the first write and by whether the 1:3 carry was dropped. The second pair is a load request or a new byte arriving in a cycle where unpacking is still running. The bench pulses these during the second write of a static byte and judges them by an unbroken column sequence and by `busy` falling after exactly eight cycles.

// File: rtl/ramld_pkg.sv
package ramld_pkg;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_DUO    = 2'd1,
        MUX_TRI    = 2'd2,
        MUX_QUAD   = 2'd3
    } mux_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_UNPACK = 1'b1
    } ld_state_e;

    // bits placed in one column for a given drive mode
    function automatic logic [2:0] group_width(input mux_mode_e m);
        return {1'b0, m} + 3'd1;
    endfunction

endpackage

// File: rtl/ramld_fsm.sv
module ramld_fsm
    import ramld_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_vld,
    input  logic ptr_ld,
    input  logic last_grp,
    output logic accept,
    output logic ld_ok,
    output logic step
);

    ld_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        ld_ok   = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ld_ok  = ptr_ld;
                accept = byte_vld;
                if (byte_vld) state_d = ST_UNPACK;   // accept
            end
            ST_UNPACK: begin
                step = 1'b1;
                if (last_grp) state_d = ST_IDLE;     // drain
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ramld_unpack.sv
module ramld_unpack
    import ramld_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int BYTE_W = 8,
    localparam int BUF_W = BYTE_W + ROWS - 1,
    localparam int CNT_W = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              flush,
    input  logic              step,
    input  logic [BYTE_W-1:0] byte_in,
    input  mux_mode_e         mode_in,
    output logic [ROWS-1:0]   grp_bits,
    output logic [ROWS-1:0]   grp_mask,
    output logic              last_grp
);

    logic [BUF_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    mux_mode_e        mode_q;
    logic [2:0]       grp_w;
    logic             keep;
    logic [BUF_W-1:0] incoming;
    logic [BUF_W-1:0] kept;
    logic [CNT_W-1:0] kept_cnt;
    logic [CNT_W:0]   two_w;

    assign grp_w    = group_width(mode_q);
    assign keep     = !flush && (mode_in == mode_q);
    assign kept     = keep ? sh_q : '0;
    assign kept_cnt = keep ? cnt_q : '0;
    assign incoming = {byte_in, {(ROWS-1){1'b0}}} >> kept_cnt;
    assign two_w    = (CNT_W+1)'(grp_w) << 1;
    assign last_grp = ({1'b0, cnt_q} < two_w);

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign grp_mask[r] = (r < int'(grp_w));
            assign grp_bits[r] = (r < int'(grp_w)) ? sh_q[BUF_W-1-r] : 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            mode_q <= MUX_STATIC;
        end else if (accept) begin
            sh_q   <= kept | incoming;
            cnt_q  <= kept_cnt + CNT_W'(BYTE_W);
            mode_q <= mode_in;
        end else if (step) begin
            sh_q   <= sh_q << grp_w;
            cnt_q  <= cnt_q - CNT_W'(grp_w);
        end else if (flush) begin
            sh_q   <= '0;
            cnt_q  <= '0;
        end
    end

endmodule

// File: rtl/ramld_ptr.sv
module ramld_ptr #(
    parameter int COLS  = 40,
    parameter int SUB_W = 3,
    localparam int PTR_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    input  logic             step,
    output logic [PTR_W-1:0] col,
    output logic [SUB_W-1:0] sub
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(COLS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col <= '0;
            sub <= '0;
        end else if (ld) begin
            col <= (ld_val > LAST) ? LAST : ld_val;
        end else if (step) begin
            if (col == LAST) begin
                col <= '0;
                sub <= sub + SUB_W'(1);
            end else begin
                col <= col + PTR_W'(1);
            end
        end
    end

endmodule

// File: rtl/seg_ram_loader.sv
module seg_ram_loader
    import ramld_pkg::*;
#(
    parameter int COLS   = 40,
    parameter int ROWS   = 4,
    parameter int BYTE_W = 8,
    parameter int SUB_W  = 3,
    localparam int PTR_W = $clog2(COLS),
    localparam int MODE_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              ptr_ld,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic [MODE_W-1:0] mux_mode,
    input  logic [SUB_W-1:0]  hw_sub,
    output logic              busy,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_col,
    output logic [ROWS-1:0]   wr_mask,
    output logic [ROWS-1:0]   wr_data
);

    logic             accept, ld_ok, step, last_grp;
    logic [SUB_W-1:0] sub;

    ramld_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .ptr_ld   (ptr_ld),
        .last_grp (last_grp),
        .accept   (accept),
        .ld_ok    (ld_ok),
        .step     (step)
    );

    ramld_unpack #(.ROWS(ROWS), .BYTE_W(BYTE_W)) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .flush    (ld_ok),
        .step     (step),
        .byte_in  (byte_data),
        .mode_in  (mux_mode_e'(mux_mode)),
        .grp_bits (wr_data),
        .grp_mask (wr_mask),
        .last_grp (last_grp)
    );

    ramld_ptr #(.COLS(COLS), .SUB_W(SUB_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_ok),
        .ld_val (ptr_val),
        .step   (step),
        .col    (wr_col),
        .sub    (sub)
    );

    assign busy  = step;
    assign wr_en = step && (sub == hw_sub);

endmodule

// File: rtl/ramld_chk.sv
module ramld_chk #(
    parameter int COLS  = 40,
    parameter int ROWS  = 4,
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld,
    input logic             busy,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_col,
    input logic [ROWS-1:0]  wr_mask
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(COLS - 1);

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && byte_vld) |=> busy);

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_col != LAST) |=> (!busy || wr_col == $past(wr_col) + PTR_W'(1)));

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_col == LAST) |=> (!busy || wr_col == '0));

    // R9
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_col <= LAST);

    // R8
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);

    // R5
    mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wr_mask[0] && $onehot0({1'b0, wr_mask} + (ROWS+1)'(1))));

endmodule

bind seg_ram_loader ramld_chk #(.COLS(COLS), .ROWS(ROWS), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .busy     (busy),
    .wr_en    (wr_en),
    .wr_col   (wr_col),
    .wr_mask  (wr_mask)
);

// File: tb/sim_seg_ram_loader.sv
module sim_seg_ram_loader;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       ptr_ld = 1'b0;
    logic [5:0] ptr_val = '0;
    logic [1:0] mux_mode = 2'd0;
    logic [2:0] hw_sub = 3'd0;
    logic       busy, wr_en;
    logic [5:0] wr_col;
    logic [3:0] wr_mask, wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // bench model of pointer, subaddress and carried bits
    int m_col = 0;
    int m_sub = 0;
    int m_left = 0;
    int m_mode = 0;
    bit m_bits [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_ram_loader u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .ptr_ld(ptr_ld), .ptr_val(ptr_val), .mux_mode(mux_mode), .hw_sub(hw_sub),
        .busy(busy), .wr_en(wr_en), .wr_col(wr_col), .wr_mask(wr_mask), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // noise: 0 none, 1 pointer load during busy, 2 byte during busy
    task automatic send_byte(input logic [7:0] b, input bit with_ld, input logic [5:0] ldv,
                             input int noise, input string req);
        int w, n, ng, rem, ed, em;
        @(negedge clk);
        chk(req, "idle before byte", int'(busy), 0);
        if (with_ld) begin
            m_col  = (int'(ldv) >= 40) ? 39 : int'(ldv);
            m_left = 0;
            ptr_ld  = 1'b1;
            ptr_val = ldv;
        end
        if (int'(mux_mode) != m_mode) m_left = 0;
        m_mode = int'(mux_mode);
        w = m_mode + 1;
        for (int i = 0; i < 8; i++) m_bits[m_left + i] = b[7 - i];
        n  = m_left + 8;
        ng = n / w;
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld = 1'b0;
        ptr_ld   = 1'b0;
        for (int g = 0; g < ng; g++) begin
            ed = 0;
            for (int r = 0; r < w; r++) if (m_bits[g*w + r]) ed |= (1 << r);
            em = (1 << w) - 1;
            chk(req, "busy", int'(busy), 1);
            chk(req, "column", int'(wr_col), m_col);
            chk(req, "mask", int'(wr_mask), em);
            chk(req, "data", int'(wr_data), ed);
            chk(req, "write enable", int'(wr_en), (m_sub == int'(hw_sub)) ? 1 : 0);
            if (m_col == 39) begin
                m_col = 0;
                m_sub = (m_sub + 1) % 8;
            end else begin
                m_col++;
            end
            if (g == 0 && noise == 1) begin ptr_ld = 1'b1; ptr_val = 6'd5; end
            if (g == 0 && noise == 2) begin byte_vld = 1'b1; byte_data = 8'hFF; end
            if (g == 1) begin ptr_ld = 1'b0; byte_vld = 1'b0; end
            @(negedge clk);
        end
        chk(req, "busy after last group", int'(busy), 0);
        rem = n - ng * w;
        for (int i = 0; i < rem; i++) m_bits[i] = m_bits[ng*w + i];
        m_left = rem;
    endtask

    task automatic load_ptr(input logic [5:0] v);
        @(negedge clk);
        ptr_ld  = 1'b1;
        ptr_val = v;
        @(negedge clk);
        ptr_ld = 1'b0;
        m_col  = (int'(v) >= 40) ? 39 : int'(v);
        m_left = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "wr_en after reset", int'(wr_en), 0);
        chk("R1", "column after reset", int'(wr_col), 0);
    endtask

    task automatic t_static();
        mux_mode = 2'd0;
        send_byte(8'hA5, 1'b0, '0, 0, "R2");
        send_byte(8'h3C, 1'b0, '0, 0, "R2");
    endtask

    task automatic t_duo();
        mux_mode = 2'd1;
        load_ptr(6'd10);
        send_byte(8'h9C, 1'b0, '0, 0, "R3");
    endtask

    task automatic t_quad();
        mux_mode = 2'd3;
        send_byte(8'hD2, 1'b0, '0, 0, "R4");
    endtask

    task automatic t_tri();
        mux_mode = 2'd2;
        load_ptr(6'd0);
        send_byte(8'hB6, 1'b0, '0, 0, "R5");
        send_byte(8'h5D, 1'b0, '0, 0, "R5");
        send_byte(8'hE3, 1'b0, '0, 0, "R5");
    endtask

    task automatic t_carry_drop();
        mux_mode = 2'd2;
        send_byte(8'h81, 1'b0, '0, 0, "R10");   // leaves 2 carried bits
        mux_mode = 2'd3;
        send_byte(8'h7E, 1'b0, '0, 0, "R10");   // mode change drops them
        mux_mode = 2'd2;
        send_byte(8'hC3, 1'b0, '0, 0, "R10");   // leaves 2 carried bits
        send_byte(8'h5A, 1'b1, 6'd20, 0, "R10"); // load with byte drops them
    endtask

    task automatic t_wrap();
        mux_mode = 2'd0;
        load_ptr(6'd38);
        send_byte(8'hF0, 1'b0, '0, 0, "R7");    // 38,39 then 0.. with sub 1
        chk("R8", "model subaddress after wrap", m_sub, 1);
        hw_sub = 3'd1;
        send_byte(8'h0F, 1'b0, '0, 0, "R8");
    endtask

    task automatic t_clamp();
        mux_mode = 2'd3;
        load_ptr(6'd50);
        send_byte(8'h96, 1'b0, '0, 0, "R9");    // starts at 39
        load_ptr(6'd63);
        send_byte(8'h69, 1'b0, '0, 0, "R9");
    endtask

    task automatic t_busy_ignore();
        mux_mode = 2'd0;
        load_ptr(6'd12);
        send_byte(8'h55, 1'b0, '0, 1, "R9");    // load during busy ignored
        send_byte(8'hAA, 1'b0, '0, 2, "R6");    // byte during busy ignored
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_static();
        t_duo();
        t_quad();
        t_tri();
        t_carry_drop();
        t_wrap();
        t_clamp();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule